// File: doc/BRIEF.md
# Chainable Timer Pair with Watchdog Reset

The block holds two 16-bit up-counters. Each one advances either once per machine cycle (timer use) or once per falling transition seen on its own external count pin (event-counter use). Each can run on its own with its own run enable and its own overflow flag. A control register can instead chain the pair into one 32-bit counter, with the first half as the low word and the second half as the high word. In that case the chain's run/stop state comes only from the control bit.

A second control bit turns any overflow into a watchdog event. The overflow can come from either half running alone or from the chained 32-bit counter. On the machine cycle after such an overflow, the block raises a synchronous reset request and holds it for a fixed number of machine cycles. While the request is high, every register in the block is held at its reset value. This also drops the watchdog enable bit, so the watchdog stays off after the release until software sets it again.

Top module: `chain_timer_wdog`

## Requirements
- R1: After reset both counts are zero, both overflow flags are zero, `ctrlQ` reads 0x00 and `rstReq` is low.
- R2: In timer use (`ctSel[i]`=0) with `runEn[i]`=1 and the pair not chained, a half advances by exactly 1 on every clock with `tickEn` high. A half does not change on clocks with `tickEn` low or with `runEn[i]`=0.
- R3: In event-counter use (`ctSel[i]`=1), a half advances by 1 only on a tick where `cntIn[i]` is low and the value sampled at the previous tick was high. The input is sampled only on ticks.
- R4: When a half runs alone, stepping it from 0xFFFF wraps it to 0x0000 and sets `ovfQ[i]`. The flag stays set until a pulse on `clrOvf[i]`. If a flag is set and cleared in the same cycle, the set wins.
- R5: Control bit 6 chains the pair. While it is 1, half 0 counts under `ctSel[0]` regardless of `runEn`, and half 1 advances only on the carry out of half 0 stepping from 0xFFFF. While it is 0, the chain is stopped.
- R6: In chained use, a step from 0xFFFF_FFFF wraps both halves to zero and sets `ovfQ[1]` only. `ovfQ[0]` is never set by the chained counter.
- R7: A write through `ldEn[i]` with `ldData` takes effect on the next clock edge and wins over an increment in the same cycle. A write to half 0 in chained use also suppresses the carry into half 1.
- R8: The control register keeps only bit 6 (chain) and bit 7 (watchdog enable). All other bits read back as 0 on `ctrlQ`.
- R9: With bit 7 set, an overflow (of a lone half or of the chain) raises `rstReq` at the end of the next tick. `rstReq` then stays high for exactly 5 ticks.
- R10: While `rstReq` is high, the counts, the flags and the control register are held at their reset values, and writes to them are ignored. After the release, bit 7 reads 0.
- R11: With bit 7 clear, overflows never raise `rstReq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-clock machine-cycle tick |
| cntIn | input | 2 | External count pins, one per half |
| ctSel | input | 2 | Per half: 0 timer use, 1 event-counter use |
| runEn | input | 2 | Per-half run enable, used when not chained |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control write data (bit 6 chain, bit 7 watchdog) |
| ctrlQ | output | 8 | Control register readback |
| ldEn | input | 2 | Per-half write strobe |
| ldData | input | 16 | Value written into the selected half(s) |
| cnt0Q | output | 16 | Half 0 count (low word when chained) |
| cnt1Q | output | 16 | Half 1 count (high word when chained) |
| clrOvf | input | 2 | Per-half overflow flag clear |
| ovfQ | output | 2 | Per-half overflow flags |
| rstReq | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with its default 16-bit halves and a 5-tick reset window. This makes it necessary to preload the counts near all-ones to reach wraps. With that preload, one or two ticks reach both a lone-half wrap and a full 32-bit chained wrap, and the window's exact rise and fall edges can be counted tick by tick. Writes are placed inside the reset window to show that the window blocks them. Event counting is driven with a mixed high/low pin pattern in which only the high-then-low pairs must count.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  localparam int CTRL_W    = 8;
  localparam int CHAIN_BIT = 6;
  localparam int WDOG_BIT  = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK =
    CTRL_W'((1 << CHAIN_BIT) | (1 << WDOG_BIT));

  typedef struct packed {
    logic       hold;
    logic [1:0] inc;
    logic [1:0] ld;
    logic [1:0] setOvf;
  } ctwStrobe_t;
endpackage

// File: rtl/ctw_ctrl.sv
module ctw_ctrl
  import ctw_pkg::*;
#(
  parameter int HOLD_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [1:0]        cntIn,
  input  logic [1:0]        ctSel,
  input  logic [1:0]        runEn,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic [1:0]        ldEn,
  input  logic [1:0]        term,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              rstReq,
  output ctwStrobe_t        strb
);
  localparam int HCW = $clog2(HOLD_TICKS + 1);

  logic [CTRL_W-1:0] ctrlR;
  logic [1:0]        smpR;
  logic [1:0]        ev;
  logic              pendR;
  logic              reqR;
  logic [HCW-1:0]    holdCnt;
  logic              chainOn;
  logic              wdogOn;
  logic              ovfEvt;

  assign chainOn = ctrlR[CHAIN_BIT];
  assign wdogOn  = ctrlR[WDOG_BIT];

  // per-half step source: machine tick or high-then-low pin pair
  for (genvar i = 0; i < 2; i++) begin : g_src
    assign ev[i] = tickEn & (ctSel[i] ? (smpR[i] & ~cntIn[i]) : 1'b1);
  end

  always_comb begin
    strb.hold      = reqR;
    strb.ld        = ldEn & {2{~reqR}};
    strb.inc[0]    = ~reqR & ~ldEn[0] & ev[0] & (chainOn | runEn[0]);
    strb.inc[1]    = ~reqR & ~ldEn[1] &
                     (chainOn ? (strb.inc[0] & term[0]) : (runEn[1] & ev[1]));
    strb.setOvf[0] = ~chainOn & strb.inc[0] & term[0];
    strb.setOvf[1] = strb.inc[1] & term[1];
  end

  assign ovfEvt = |strb.setOvf;
  assign ctrlQ  = ctrlR;
  assign rstReq = reqR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR <= '0;
      smpR  <= '0;
    end else if (reqR) begin
      ctrlR <= '0;
      smpR  <= '0;
    end else begin
      if (ctrlWe) ctrlR <= ctrlWdata & CTRL_MASK;
      if (tickEn) smpR <= cntIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendR   <= 1'b0;
      reqR    <= 1'b0;
      holdCnt <= '0;
    end else begin
      if (tickEn && pendR) begin
        reqR    <= 1'b1;
        holdCnt <= HCW'(HOLD_TICKS);
        pendR   <= 1'b0;
      end else if (tickEn && reqR) begin
        holdCnt <= holdCnt - 1'b1;
        if (holdCnt == HCW'(1)) reqR <= 1'b0;
      end else if (ovfEvt && wdogOn && !reqR) begin
        pendR <= 1'b1;
      end
    end
  end

  // R9: the request only starts from a pending watchdog overflow
  assert_req_from_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqR) |-> $past(pendR));
  // R9: a request is only dropped on a tick
  assert_release_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqR) |-> $past(tickEn));
  // R11: no pending event arises while the watchdog is off
  assert_no_wdog_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!wdogOn && !pendR) |=> !pendR);
  // R10: control register is cleared by the request window
  assert_ctrl_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqR |=> ctrlR == '0);
endmodule

// File: rtl/ctw_datapath.sv
module ctw_datapath
  import ctw_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctwStrobe_t             strb,
  input  logic [HALF_W-1:0]      ldData,
  input  logic [1:0]             clrOvf,
  output logic [1:0][HALF_W-1:0] cntQ,
  output logic [1:0]             ovfQ,
  output logic [1:0]             term
);
  logic [HALF_W-1:0] cntR [2];
  logic [1:0]        ovfR;

  for (genvar i = 0; i < 2; i++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntR[i] <= '0;
        ovfR[i] <= 1'b0;
      end else if (strb.hold) begin
        cntR[i] <= '0;
        ovfR[i] <= 1'b0;
      end else begin
        if (strb.ld[i])       cntR[i] <= ldData;
        else if (strb.inc[i]) cntR[i] <= cntR[i] + 1'b1;
        if (strb.setOvf[i])   ovfR[i] <= 1'b1;
        else if (clrOvf[i])   ovfR[i] <= 1'b0;
      end
    end

    assign cntQ[i] = cntR[i];
    assign term[i] = &cntR[i];

    // R2: a half with no strobe keeps its value
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.inc[i] && !strb.ld[i] && !strb.hold) |=> $stable(cntR[i]));
    // R7: a write lands even when an increment was requested
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      strb.ld[i] |=> cntR[i] == $past(ldData));
    // R10: the reset window clears counts and flags
    assert_hold_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb.hold |=> (cntR[i] == '0 && !ovfR[i]));
    // R4: a flag only rises together with a wrap to zero
    assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfR[i]) |-> cntR[i] == '0);
  end

  assign ovfQ = ovfR;
endmodule

// File: rtl/chain_timer_wdog.sv
module chain_timer_wdog
  import ctw_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int HOLD_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [1:0]        cntIn,
  input  logic [1:0]        ctSel,
  input  logic [1:0]        runEn,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlQ,
  input  logic [1:0]        ldEn,
  input  logic [HALF_W-1:0] ldData,
  output logic [HALF_W-1:0] cnt0Q,
  output logic [HALF_W-1:0] cnt1Q,
  input  logic [1:0]        clrOvf,
  output logic [1:0]        ovfQ,
  output logic              rstReq
);
  ctwStrobe_t              strb;
  logic [1:0]              term;
  logic [1:0][HALF_W-1:0]  cntQ;

  ctw_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntIn(cntIn), .ctSel(ctSel),
    .runEn(runEn), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ldEn(ldEn),
    .term(term), .ctrlQ(ctrlQ), .rstReq(rstReq), .strb(strb)
  );

  ctw_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldData(ldData), .clrOvf(clrOvf),
    .cntQ(cntQ), .ovfQ(ovfQ), .term(term)
  );

  assign cnt0Q = cntQ[0];
  assign cnt1Q = cntQ[1];
endmodule

// File: tb/tb_chain_timer_wdog.sv
module tb_chain_timer_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic [1:0]    cntIn = '0, ctSel = '0, runEn = '0, ldEn = '0, clrOvf = '0;
  logic          ctrlWe = 1'b0;
  logic [7:0]    ctrlWdata = '0;
  logic [7:0]    ctrlQ;
  logic [HW-1:0] ldData = '0, cnt0Q, cnt1Q;
  logic [1:0]    ovfQ;
  logic          rstReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_timer_wdog dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntIn(cntIn), .ctSel(ctSel),
    .runEn(runEn), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlQ(ctrlQ),
    .ldEn(ldEn), .ldData(ldData), .cnt0Q(cnt0Q), .cnt1Q(cnt1Q),
    .clrOvf(clrOvf), .ovfQ(ovfQ), .rstReq(rstReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tickN(input int n);
    @(negedge clk); tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic tickWith(input logic v);
    @(negedge clk); cntIn[0] = v; tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic load(input logic [1:0] which, input logic [HW-1:0] v);
    @(negedge clk); ldEn = which; ldData = v;
    @(negedge clk); ldEn = '0;
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic clrFlags();
    @(negedge clk); clrOvf = 2'b11;
    @(negedge clk); clrOvf = 2'b00;
  endtask

  task automatic testReset();
    chk("R1 cnt0", 32'(cnt0Q), 0);
    chk("R1 cnt1", 32'(cnt1Q), 0);
    chk("R1 flags", 32'(ovfQ), 0);
    chk("R1 ctrl", 32'(ctrlQ), 0);
    chk("R1 rstReq", 32'(rstReq), 0);
  endtask

  task automatic testTimer();
    ctSel = 2'b00; runEn = 2'b01;
    tickN(7);
    chk("R2 cnt0 after 7 ticks", 32'(cnt0Q), 7);
    chk("R2 cnt1 not running", 32'(cnt1Q), 0);
    repeat (3) @(negedge clk);
    chk("R2 no tick no step", 32'(cnt0Q), 7);
    runEn = 2'b11;
    tickN(3);
    chk("R2 cnt0 both run", 32'(cnt0Q), 10);
    chk("R2 cnt1 both run", 32'(cnt1Q), 3);
    runEn = 2'b00;
  endtask

  task automatic testLoadPriority();
    runEn = 2'b01;
    @(negedge clk); tickEn = 1'b1; ldEn = 2'b01; ldData = 16'h1234;
    @(negedge clk); tickEn = 1'b0; ldEn = 2'b00;
    chk("R7 write beats step", 32'(cnt0Q), 32'h1234);
    runEn = 2'b00;
  endtask

  task automatic testWrap();
    load(2'b01, 16'hFFFE);
    runEn = 2'b01;
    tickN(2);
    chk("R4 wrap to zero", 32'(cnt0Q), 0);
    chk("R4 flag set", 32'(ovfQ), 32'b01);
    repeat (3) @(negedge clk);
    chk("R4 flag sticky", 32'(ovfQ), 32'b01);
    @(negedge clk); clrOvf = 2'b01;
    @(negedge clk); clrOvf = 2'b00;
    chk("R4 flag cleared", 32'(ovfQ), 0);
    runEn = 2'b00;
  endtask

  task automatic testEvent();
    load(2'b01, 16'h0000);
    ctSel = 2'b01; runEn = 2'b01;
    tickWith(1); tickWith(1); tickWith(0); tickWith(0);
    tickWith(1); tickWith(0); tickWith(1); tickWith(1);
    chk("R3 only high-then-low pairs count", 32'(cnt0Q), 2);
    @(negedge clk); cntIn[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 no sample without tick", 32'(cnt0Q), 2);
    ctSel = 2'b00; runEn = 2'b00; cntIn = '0;
    tickN(1);
  endtask

  task automatic testChain();
    load(2'b01, 16'hFFFE);
    load(2'b10, 16'h0005);
    runEn = 2'b00;
    wrCtrl(8'h40);
    chk("R8 chain bit readback", 32'(ctrlQ), 32'h40);
    tickN(3);
    chk("R5 low word", 32'(cnt0Q), 1);
    chk("R5 high word carry", 32'(cnt1Q), 6);
    chk("R6 no low flag in chain", 32'(ovfQ), 0);
    wrCtrl(8'h00);
    tickN(4);
    chk("R5 stopped low", 32'(cnt0Q), 1);
    chk("R5 stopped high", 32'(cnt1Q), 6);
  endtask

  task automatic testChainWrap();
    load(2'b11, 16'hFFFF);
    wrCtrl(8'h40);
    tickN(1);
    chk("R6 low word wrap", 32'(cnt0Q), 0);
    chk("R6 high word wrap", 32'(cnt1Q), 0);
    chk("R6 only high flag", 32'(ovfQ), 32'b10);
    wrCtrl(8'h00);
    clrFlags();
  endtask

  task automatic testCtrlMask();
    wrCtrl(8'hFF);
    chk("R8 reserved bits read zero", 32'(ctrlQ), 32'hC0);
    wrCtrl(8'h3F);
    chk("R8 reserved only", 32'(ctrlQ), 0);
  endtask

  task automatic testWdogSingle();
    int highCnt = 0;
    load(2'b01, 16'hFFFF);
    load(2'b10, 16'h0ABC);
    runEn = 2'b01; ctSel = 2'b00;
    wrCtrl(8'h80);
    @(negedge clk); tickEn = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (rstReq) highCnt++;
      if (k == 1) begin
        chk("R9 no request on overflow tick", 32'(rstReq), 0);
        chk("R4 flag on lone wrap", 32'(ovfQ), 32'b01);
      end
      if (k == 2) chk("R9 request next tick", 32'(rstReq), 1);
      if (k == 3) begin
        chk("R10 high half cleared", 32'(cnt1Q), 0);
        chk("R10 flags cleared", 32'(ovfQ), 0);
        chk("R10 ctrl cleared", 32'(ctrlQ), 0);
        ldEn = 2'b10; ldData = 16'h7777;
        ctrlWe = 1'b1; ctrlWdata = 8'h40;
      end
      if (k == 4) begin
        ldEn = 2'b00; ctrlWe = 1'b0;
        chk("R10 write ignored", 32'(cnt1Q), 0);
        chk("R10 ctrl write ignored", 32'(ctrlQ), 0);
      end
      if (k == 7) begin
        chk("R9 released after window", 32'(rstReq), 0);
        chk("R10 watchdog bit clear", 32'(ctrlQ), 0);
      end
    end
    tickEn = 1'b0;
    chk("R9 window length", 32'(highCnt), 5);
    runEn = 2'b00;
  endtask

  task automatic testWdogChain();
    int highCnt = 0;
    load(2'b11, 16'hFFFF);
    wrCtrl(8'hC0);
    @(negedge clk); tickEn = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (rstReq) highCnt++;
      if (k == 1) chk("R6 chain flag before request", 32'(ovfQ), 32'b10);
      if (k == 2) chk("R9 chained request", 32'(rstReq), 1);
    end
    tickEn = 1'b0;
    chk("R9 chained window length", 32'(highCnt), 5);
  endtask

  task automatic testNoWdog();
    int seen = 0;
    wrCtrl(8'h00);
    load(2'b01, 16'hFFFF);
    runEn = 2'b01;
    @(negedge clk); tickEn = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (rstReq) seen++;
    end
    tickEn = 1'b0;
    chk("R11 overflow flag set", 32'(ovfQ[0]), 1);
    chk("R11 no request", 32'(seen), 0);
    runEn = 2'b00;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimer();
    testLoadPriority();
    testWrap();
    testEvent();
    testChain();
    testChainWrap();
    testCtrlMask();
    testWdogSingle();
    testWdogChain();
    testNoWdog();
    done = 1'b1;
    finishRun();
  end
endmodule